// File: doc/BRIEF.md
# Trace Pattern Match Unit

The unit sits beside a processor's commit stage and watches one committed-instruction record per cycle. Each record has five fields: the instruction word, the PC of that instruction, the PC that executes next (a target or a fall-through), a memory address and a data value. Software gives every field a value and a mask through a single-cycle register-write port. A mask bit of 1 means that bit is compared. A mask bit of 0 means that bit is a wildcard, so a field whose mask is zero matches anything.

The unit keeps a count of the records that match all five fields. A matching record fires an event when the count of earlier matches has reached the programmed threshold. When an event fires, the count returns to zero and the unit emits a match packet. The packet carries the unit's identifier and the address and data of the record that fired it.

Records arrive on a valid/ready stream, and packets leave on a valid/ready stream. A record transfers on a cycle where `tr_valid` and `tr_ready` are both high. A packet transfers on a cycle where `pkt_valid` and `pkt_ready` are both high. The unit holds one packet. While that packet is refused downstream, the unit raises `stall` and takes no new record, so no packet is ever lost. A clear command returns all configuration and the count to zero before the unit is reprogrammed.

Top module: `trace_match_unit`

## Requirements
- R1: After reset, `pkt_valid` and `stall` are low and `tr_ready` is high. All patterns, all masks, the threshold and the count are zero, so the first record accepted after reset emits a packet.
- R2: A field matches when `(field & mask) == (pattern & mask)`. Only bits whose mask bit is 1 are compared.
- R3: A record counts as a match only when all five fields match. A mismatch in any single field leaves the count unchanged and emits nothing.
- R4: A matching record fires an event when the count of earlier matches is equal to or greater than the threshold. With threshold T, the packet comes on the (T+1)-th match; with T = 0, every match fires. A match that does not fire increments the count.
- R5: When an event fires, the count returns to zero, and the next event again needs T+1 matches.
- R6: When an event fires on the record accepted at clock edge k, `pkt_valid` is high after edge k. The packet carries `pkt_id` = UNIT_ID, and `pkt_addr` and `pkt_data` taken from that record.
- R7: While `pkt_valid` is high and `pkt_ready` is low, the following hold: the packet stays valid with a stable payload, `stall` is high, and `tr_ready` is low. A record offered during this time is accepted on the cycle the packet is taken.
- R8: Cycles without a transfer (`tr_valid` low, or `tr_ready` low) do not change the count and emit nothing, whatever the record fields carry.
- R9: A cycle with `cfg_clear` high zeroes all patterns, all masks, the threshold and the count. Clear wins over a match or a write in the same cycle.
- R10: Writes use the following map. When `cfg_addr[3]` is 0, address `cfg_addr[2:0]` selects the pattern of a field: 0 is the instruction, 1 the PC, 2 the next PC, 3 the address, 4 the data. When `cfg_addr[3]` is 1, the same index selects that field's mask. Address 15 writes the threshold from the low CNT_W bits of `cfg_wdata`. Writes to addresses 5, 6, 7, 13 and 14 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address (see R10) |
| cfg_wdata | input | W | Configuration write data |
| cfg_clear | input | 1 | Clears patterns, masks, threshold and count |
| tr_valid | input | 1 | A trace record is offered |
| tr_ready | output | 1 | The unit takes the record this cycle |
| tr_inst | input | W | Instruction word |
| tr_pc | input | W | PC of the instruction |
| tr_npc | input | W | Next or target PC |
| tr_addr | input | W | Memory address |
| tr_data | input | W | Data value |
| pkt_valid | output | 1 | A match packet is offered |
| pkt_ready | input | 1 | The downstream queue takes the packet |
| pkt_id | output | ID_W | Identifier of this unit |
| pkt_addr | output | W | Address of the record that fired |
| pkt_data | output | W | Data of the record that fired |
| stall | output | 1 | The packet is held and the trace must wait |

## Verification
The count is not visible at the ports. If the count is wrong, packets come early or late against the threshold, or they come after a clear when none are expected. This shows up on the first record that fires, or on the first record that should have fired. A wrong pattern or mask register shows up as a missing packet or an extra packet on the next record accepted after the write. Each single-field mismatch is tried on its own so that a field that was skipped is visible. If the hold logic is wrong, the packet payload changes while `pkt_ready` is low, or a record is lost. Either of these shows up in the cycle the stalled packet is finally taken.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    FLD_INST = 3'd0,
    FLD_PC   = 3'd1,
    FLD_NPC  = 3'd2,
    FLD_ADDR = 3'd3,
    FLD_DATA = 3'd4
  } field_e;

  localparam logic [3:0] THR_ADDR = 4'hF;
endpackage

// File: rtl/tmu_cfg_regs.sv
module tmu_cfg_regs
  import tmu_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [3:0]                     addr,
  input  logic [W-1:0]                   wdata,
  input  logic                           clear,
  output logic [NUM_FIELDS-1:0][W-1:0]   pat,
  output logic [NUM_FIELDS-1:0][W-1:0]   msk,
  output logic [CNT_W-1:0]               thr
);
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pat[f] <= '0;
        msk[f] <= '0;
      end else if (clear) begin
        pat[f] <= '0;
        msk[f] <= '0;
      end else if (we && addr[IDX_W-1:0] == IDX_W'(f)) begin
        if (addr[3]) msk[f] <= wdata;
        else         pat[f] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       thr <= '0;
    else if (clear)                   thr <= '0;
    else if (we && addr == THR_ADDR)  thr <= wdata[CNT_W-1:0];
  end
endmodule

// File: rtl/tmu_field_cmp.sv
module tmu_field_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] mask,
  output logic         hit
);
  assign hit = ((value ^ pattern) & mask) == '0;
endmodule

// File: rtl/tmu_counter.sv
module tmu_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hit,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  assign fire = hit && (count >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (fire)   count <= '0;
    else if (hit)    count <= count + 1'b1;
  end
endmodule

// File: rtl/trace_match_unit.sv
module trace_match_unit
  import tmu_pkg::*;
#(
  parameter int W       = 32,
  parameter int CNT_W   = 16,
  parameter int ID_W    = 3,
  parameter int UNIT_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_addr,
  input  logic [W-1:0]    cfg_wdata,
  input  logic            cfg_clear,
  input  logic            tr_valid,
  output logic            tr_ready,
  input  logic [W-1:0]    tr_inst,
  input  logic [W-1:0]    tr_pc,
  input  logic [W-1:0]    tr_npc,
  input  logic [W-1:0]    tr_addr,
  input  logic [W-1:0]    tr_data,
  output logic            pkt_valid,
  input  logic            pkt_ready,
  output logic [ID_W-1:0] pkt_id,
  output logic [W-1:0]    pkt_addr,
  output logic [W-1:0]    pkt_data,
  output logic            stall
);
  logic [NUM_FIELDS-1:0][W-1:0] pat, msk, rec;
  logic [NUM_FIELDS-1:0]        fld_hit;
  logic [CNT_W-1:0]             thr, match_cnt;
  logic                         accept, all_hit, fire;

  assign rec[FLD_INST] = tr_inst;
  assign rec[FLD_PC]   = tr_pc;
  assign rec[FLD_NPC]  = tr_npc;
  assign rec[FLD_ADDR] = tr_addr;
  assign rec[FLD_DATA] = tr_data;

  tmu_cfg_regs #(.W(W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .clear(cfg_clear), .pat(pat), .msk(msk), .thr(thr)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
    tmu_field_cmp #(.W(W)) u_cmp (
      .value(rec[f]), .pattern(pat[f]), .mask(msk[f]), .hit(fld_hit[f])
    );
  end

  assign all_hit  = &fld_hit;
  assign stall    = pkt_valid && !pkt_ready;
  assign tr_ready = !stall;
  assign accept   = tr_valid && tr_ready;

  tmu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cfg_clear),
    .hit(accept && all_hit && !cfg_clear), .thr(thr),
    .count(match_cnt), .fire(fire)
  );

  assign pkt_id = ID_W'(UNIT_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt_addr  <= '0;
      pkt_data  <= '0;
    end else if (fire) begin
      pkt_valid <= 1'b1;
      pkt_addr  <= tr_addr;
      pkt_data  <= tr_data;
    end else if (pkt_ready) begin
      pkt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tmu_checker.sv
module tmu_checker #(
  parameter int W     = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tr_valid,
  input logic             tr_ready,
  input logic             cfg_clear,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic [W-1:0]     pkt_addr,
  input logic [W-1:0]     pkt_data,
  input logic [CNT_W-1:0] match_cnt,
  input logic             fire
);
  assert_pkt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_addr) && $stable(pkt_data)));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (match_cnt == '0));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tr_valid && tr_ready) && !cfg_clear) |=> $stable(match_cnt));

  assert_pkt_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> $past(tr_valid && tr_ready));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (match_cnt == '0 && !$rose(pkt_valid)));
endmodule

bind trace_match_unit tmu_checker #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_ready(tr_ready),
  .cfg_clear(cfg_clear), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .pkt_addr(pkt_addr), .pkt_data(pkt_data), .match_cnt(match_cnt), .fire(fire)
);

// File: tb/trace_match_unit_tb.sv
module trace_match_unit_tb;
  localparam int W = 32;
  localparam int ID_W = 3;
  localparam int UID = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_clear = 0;
  logic [3:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic tr_valid = 0, tr_ready;
  logic [W-1:0] tr_inst = '0, tr_pc = '0, tr_npc = '0, tr_addr = '0, tr_data = '0;
  logic pkt_valid, pkt_ready = 1, stall;
  logic [ID_W-1:0] pkt_id;
  logic [W-1:0] pkt_addr, pkt_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  trace_match_unit #(.W(W), .CNT_W(16), .ID_W(ID_W), .UNIT_ID(UID)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_clear(cfg_clear), .tr_valid(tr_valid),
    .tr_ready(tr_ready), .tr_inst(tr_inst), .tr_pc(tr_pc), .tr_npc(tr_npc),
    .tr_addr(tr_addr), .tr_data(tr_data), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_id(pkt_id), .pkt_addr(pkt_addr),
    .pkt_data(pkt_data), .stall(stall)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic clr();
    @(negedge clk); cfg_clear = 1;
    @(negedge clk); cfg_clear = 0;
  endtask

  // Offers one record for one edge; returns at the next negedge
  task automatic send(input logic [W-1:0] i, p, n, a, d);
    @(negedge clk);
    tr_valid = 1; tr_inst = i; tr_pc = p; tr_npc = n; tr_addr = a; tr_data = d;
    @(negedge clk);
    tr_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 pkt_valid", W'(pkt_valid), 0);
    chk("R1 stall", W'(stall), 0);
    chk("R1 tr_ready", W'(tr_ready), 1);
    send(32'h1, 32'h2, 32'h3, 32'hA0, 32'hD0);
    chk("R1 wildcard packet", W'(pkt_valid), 1);
  endtask

  task automatic t_mask();
    wr(4'd0, 32'h0000_0067); wr(4'd8, 32'h0000_007F);
    send(32'h1234_5667, 32'h10, 32'h14, 32'hA1, 32'hD1);
    chk("R2 masked hit", W'(pkt_valid), 1);
    chk("R6 id", W'(pkt_id), UID);
    chk("R6 addr", pkt_addr, 32'hA1);
    chk("R6 data", pkt_data, 32'hD1);
    send(32'h1234_5663, 32'h10, 32'h14, 32'hA2, 32'hD2);
    chk("R2 masked miss", W'(pkt_valid), 0);
  endtask

  task automatic t_allfields();
    logic [W-1:0] good [5];
    good = '{32'h67, 32'h1000, 32'h2000, 32'h3000, 32'h4000};
    for (int f = 1; f < 5; f++) begin
      wr(4'(f), good[f]); wr(4'(8 + f), '1);
    end
    for (int f = 0; f < 5; f++) begin
      logic [W-1:0] v [5];
      v = good; v[f] = v[f] ^ 32'h1;
      send(v[0], v[1], v[2], v[3], v[4]);
      chk($sformatf("R3 miss field %0d", f), W'(pkt_valid), 0);
    end
    send(good[0], good[1], good[2], good[3], good[4]);
    chk("R3 all fields hit", W'(pkt_valid), 1);
  endtask

  task automatic t_threshold();
    clr(); wr(4'hF, 32'd2);
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 2; k++) begin
        send('0, '0, '0, 32'hB0 + k, 32'hC0);
        chk("R4 below threshold", W'(pkt_valid), 0);
      end
      send('0, '0, '0, 32'hBF, 32'hCF);
      chk(r == 0 ? "R4 third match fires" : "R5 restart fires", W'(pkt_valid), 1);
      chk("R6 addr of firing record", pkt_addr, 32'hBF);
    end
  endtask

  task automatic t_idle();
    clr(); wr(4'hF, 32'd1);
    send('0, '0, '0, 32'hE0, 32'hE0);
    chk("R4 first of two", W'(pkt_valid), 0);
    @(negedge clk); tr_addr = 32'hE1;
    repeat (4) @(negedge clk);
    chk("R8 idle no packet", W'(pkt_valid), 0);
    send('0, '0, '0, 32'hE2, 32'hE2);
    chk("R8 count unchanged by idle", W'(pkt_valid), 1);
  endtask

  task automatic t_clear();
    clr(); wr(4'hF, 32'd1);
    send('0, '0, '0, 32'h1, 32'h1);
    wr(4'd0, 32'hFF); wr(4'd8, 32'hFF);
    clr();
    send(32'h5A, '0, '0, 32'h2, 32'h2);
    chk("R9 config zeroed", W'(pkt_valid), 1);
    wr(4'hF, 32'd1);
    send('0, '0, '0, 32'h3, 32'h3);
    chk("R9 count zeroed", W'(pkt_valid), 0);
  endtask

  task automatic t_map();
    clr();
    wr(4'd5, '1); wr(4'd13, '1);
    send(32'hFFFF_FFFF, 32'h5, 32'h6, 32'h7, 32'h8);
    chk("R10 unused addresses ignored", W'(pkt_valid), 1);
    wr(4'd12, 32'hF); wr(4'd4, 32'h9);
    send('0, '0, '0, 32'h7, 32'h8);
    chk("R10 data mask address", W'(pkt_valid), 0);
    send('0, '0, '0, 32'h7, 32'h9);
    chk("R10 data pattern address", W'(pkt_valid), 1);
  endtask

  task automatic t_backpressure();
    clr();
    @(negedge clk); pkt_ready = 0;
    send('0, '0, '0, 32'hAA, 32'hA1);
    chk("R7 packet A", W'(pkt_valid), 1);
    chk("R7 stall", W'(stall), 1);
    chk("R7 tr_ready low", W'(tr_ready), 0);
    tr_valid = 1; tr_addr = 32'hBB; tr_data = 32'hB1;
    repeat (3) @(negedge clk);
    chk("R7 hold valid", W'(pkt_valid), 1);
    chk("R7 hold data", pkt_data, 32'hA1);
    pkt_ready = 1;
    @(negedge clk); tr_valid = 0;
    chk("R7 B accepted on release", pkt_data, 32'hB1);
    chk("R7 B valid", W'(pkt_valid), 1);
    @(negedge clk);
    chk("R7 drained", W'(pkt_valid), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_allfields();
        t_threshold();
        t_idle();
        t_clear();
        t_map();
        t_backpressure();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule